// File: doc/BRIEF.md
# Complementary PWM Dead-Band and Park Stage

This block sits between a timer's PWM reference outputs and the pins of a motor drive. Each of its channels takes one reference signal and turns it into a complementary pair: a direct output and a complementary output. When dead band is enabled on a channel, the turn-on of each output is held back by a programmable number of system clocks. The two outputs of that channel are therefore never high together across a transition. When dead band is disabled, the direct output follows the reference and the complementary output is its inverse.

A park override comes after the dead-band logic. It is selected by a 2-bit control and triggered by a fault or debug-halt condition. While the override is active, each of the six outputs is driven to its own preset level, so the power stage sees known safe levels. The override takes effect in the same cycle as its trigger and is released as soon as the trigger goes away.

Top module: `pwm_deadband_park`

## Requirements
- R1: On a channel whose dead-band enable is 0, and while not parked, the direct output equals the reference and the complementary output equals its inverse, with no delay.
- R2: With dead band enabled, the direct output goes high only once the reference has been high for `rise_dly` consecutive clock edges, counted from the cycle in which the reference rose. A delay of 0 gives no added delay.
- R3: With dead band enabled, the complementary output goes high only once the reference has been low for `fall_dly` consecutive clock edges, counted from the cycle in which the reference fell.
- R4: With dead band enabled, the direct output drops in the same cycle as a falling reference, and the complementary output drops in the same cycle as a rising reference.
- R5: A reference high or low phase shorter than the applicable delay produces no pulse at all on the delayed output.
- R6: While not parked, the direct and complementary outputs of a channel are never high at the same time.
- R7: Park select encoding is as follows: 0 never parks, 1 parks on `fault_act`, 2 parks on `dbg_halt`, and 3 parks on either.
- R8: While parked, `park_lvl[2*i]` drives direct output i and `park_lvl[2*i+1]` drives complementary output i. A value of 1 drives the output high.
- R9: The park override applies in the same cycle as the selected condition becomes true and is released in the same cycle as it goes false. The dead-band timing continues to run underneath.
- R10: Bit i of `db_en` enables dead band on channel i only.
- R11: In reset, the dead-band counters are cleared. A dead-band-enabled channel with a low reference and a nonzero fall delay therefore drives both outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | CH | PWM reference per channel |
| rise_dly | input | DW | Delay before the direct output turns on |
| fall_dly | input | DW | Delay before the complementary output turns on |
| db_en | input | CH | Dead-band enable per channel |
| park_sel | input | 2 | Park trigger select |
| park_lvl | input | 2*CH | Park levels: direct i at bit 2i, complementary i at bit 2i+1 |
| fault_act | input | 1 | Fault condition active |
| dbg_halt | input | 1 | Debug halt active |
| pin_hi | output | CH | Direct outputs |
| pin_lo | output | CH | Complementary outputs |

## Verification
The only internal state in the block is the pair of run-length counters on each channel. If a counter fails to clear or misses a count, the effect appears at the next reference transition. The delayed output then turns on one or more cycles early or late, or it emits a short pulse that should have been suppressed. The bench compares every output bit on every cycle against a model built from the requirements. A counter fault is therefore caught within the first delay window that follows it. Park errors involve no state, so they show up in the same cycle as the trigger.

// File: rtl/pwm_deadband_park.sv
module pwm_deadband_park #(
  parameter int CH = 3,
  parameter int DW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH-1:0]   ref_in,
  input  logic [DW-1:0]   rise_dly,
  input  logic [DW-1:0]   fall_dly,
  input  logic [CH-1:0]   db_en,
  input  logic [1:0]      park_sel,
  input  logic [2*CH-1:0] park_lvl,
  input  logic            fault_act,
  input  logic            dbg_halt,
  output logic [CH-1:0]   pin_hi,
  output logic [CH-1:0]   pin_lo
);
  localparam logic [DW-1:0] CMAX = {DW{1'b1}};

  logic park_on;
  assign park_on = (park_sel[0] & fault_act) | (park_sel[1] & dbg_halt);

  for (genvar g = 0; g < CH; g++) begin : g_ch
    logic [DW-1:0] hi_run, lo_run;
    logic          db_hi, db_lo;

    // run lengths of the current reference level, saturating
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_run <= '0;
        lo_run <= '0;
      end else if (ref_in[g]) begin
        hi_run <= (hi_run == CMAX) ? hi_run : hi_run + 1'b1;
        lo_run <= '0;
      end else begin
        lo_run <= (lo_run == CMAX) ? lo_run : lo_run + 1'b1;
        hi_run <= '0;
      end
    end

    assign db_hi = db_en[g] ? (ref_in[g] && hi_run >= rise_dly) : ref_in[g];
    assign db_lo = db_en[g] ? (!ref_in[g] && lo_run >= fall_dly) : !ref_in[g];

    assign pin_hi[g] = park_on ? park_lvl[2*g]   : db_hi;
    assign pin_lo[g] = park_on ? park_lvl[2*g+1] : db_lo;
  end
endmodule

module pwm_deadband_park_chk #(
  parameter int CH = 3,
  parameter int DW = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CH-1:0]   ref_in,
  input logic [DW-1:0]   rise_dly,
  input logic [DW-1:0]   fall_dly,
  input logic [CH-1:0]   db_en,
  input logic [1:0]      park_sel,
  input logic [2*CH-1:0] park_lvl,
  input logic            fault_act,
  input logic            dbg_halt,
  input logic [CH-1:0]   pin_hi,
  input logic [CH-1:0]   pin_lo
);
  logic parked;
  assign parked = (park_sel == 2'd3) ? (fault_act || dbg_halt) :
                  (park_sel == 2'd1) ? fault_act :
                  (park_sel == 2'd2) ? dbg_halt : 1'b0;

  for (genvar g = 0; g < CH; g++) begin : g_chk
    p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!parked && !db_en[g]) |-> (pin_hi[g] == ref_in[g] && pin_lo[g] == !ref_in[g]));

    p_rise_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!parked && db_en[g] && ref_in[g] && !$past(ref_in[g]) && rise_dly != '0) |-> !pin_hi[g]);

    p_fast_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!parked && db_en[g]) |-> ((!ref_in[g] -> !pin_hi[g]) && (ref_in[g] -> !pin_lo[g])));

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !parked |-> !(pin_hi[g] && pin_lo[g]));

    p_park_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      parked |-> (pin_hi[g] == park_lvl[2*g] && pin_lo[g] == park_lvl[2*g+1]));
  end
endmodule

bind pwm_deadband_park pwm_deadband_park_chk #(.CH(CH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .rise_dly(rise_dly),
  .fall_dly(fall_dly), .db_en(db_en), .park_sel(park_sel),
  .park_lvl(park_lvl), .fault_act(fault_act), .dbg_halt(dbg_halt),
  .pin_hi(pin_hi), .pin_lo(pin_lo)
);

// File: tb/pwm_deadband_park_bench.sv
module pwm_deadband_park_bench;
  localparam int CH = 3;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CH-1:0]   ref_in = '0;
  logic [DW-1:0]   rise_dly = '0, fall_dly = '0;
  logic [CH-1:0]   db_en = '0;
  logic [1:0]      park_sel = '0;
  logic [2*CH-1:0] park_lvl = '0;
  logic            fault_act = 1'b0, dbg_halt = 1'b0;
  logic [CH-1:0]   pin_hi, pin_lo;

  // next-cycle settings, applied by step()
  logic [DW-1:0]   nx_rise = 12'd3, nx_fall = 12'd2;
  logic [CH-1:0]   nx_db = 3'b111;
  logic [1:0]      nx_sel = 2'd0;
  logic [2*CH-1:0] nx_lvl = '0;

  always #10 clk = ~clk;

  pwm_deadband_park #(.CH(CH), .DW(DW)) u_pwm_deadband_park (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .rise_dly(rise_dly),
    .fall_dly(fall_dly), .db_en(db_en), .park_sel(park_sel),
    .park_lvl(park_lvl), .fault_act(fault_act), .dbg_halt(dbg_halt),
    .pin_hi(pin_hi), .pin_lo(pin_lo)
  );

  typedef struct {
    logic [CH-1:0] hi;
    logic [CH-1:0] lo;
    logic          parked;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0;
  int run[CH];
  logic [CH-1:0] prev_ref = '0;
  bit done = 0;

  task automatic step(input logic [CH-1:0] r, input logic f, input logic d, input string tag);
    exp_t e;
    logic pk;
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    ref_in = r; fault_act = f; dbg_halt = d;
    rise_dly = nx_rise; fall_dly = nx_fall; db_en = nx_db;
    park_sel = nx_sel; park_lvl = nx_lvl;
    pk = (nx_sel[0] & f) | (nx_sel[1] & d);
    for (int i = 0; i < CH; i++) begin
      run[i] = (r[i] == prev_ref[i]) ? run[i] + 1 : 0;
      if (pk) begin
        e.hi[i] = nx_lvl[2*i];
        e.lo[i] = nx_lvl[2*i+1];
      end else if (!nx_db[i]) begin
        e.hi[i] = r[i];
        e.lo[i] = !r[i];
      end else begin
        e.hi[i] = r[i] && (run[i] >= int'(nx_rise));
        e.lo[i] = !r[i] && (run[i] >= int'(nx_fall));
      end
    end
    prev_ref = r;
    e.parked = pk;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic hold(input logic [CH-1:0] r, input int n, input string tag);
    for (int k = 0; k < n; k++) step(r, 1'b0, 1'b0, tag);
  endtask

  // monitor: compare one scoreboard item per cycle
  always @(negedge clk) begin
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (pin_hi !== e.hi || pin_lo !== e.lo) begin
        fails++;
        $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", e.tag, pin_hi, pin_lo, e.hi, e.lo);
      end
      if (!e.parked) begin
        checks++;
        if ((pin_hi & pin_lo) !== '0) begin
          fails++;
          $display("FAIL R6: overlap hi=%b lo=%b expected no common bit", pin_hi, pin_lo);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < CH; i++) run[i] = -1;
    rise_dly = 12'd3; fall_dly = 12'd2; db_en = 3'b111;
    repeat (2) @(negedge clk);
    // R11: reset state with dead band on, fall delay 2
    checks++;
    if (pin_hi !== '0 || pin_lo !== '0) begin
      fails++;
      $display("FAIL R11: hi=%b lo=%b expected hi=000 lo=000", pin_hi, pin_lo);
    end

    // dead band on all channels, rise 3, fall 2
    hold(3'b000, 3, "R11");
    hold(3'b111, 6, "R2");
    hold(3'b000, 5, "R3");
    hold(3'b111, 2, "R5");
    hold(3'b000, 1, "R5");
    hold(3'b111, 4, "R4");
    hold(3'b000, 3, "R4");

    // R10: only channel 1 delayed; R1 bypass on channels 0 and 2
    nx_db = 3'b010;
    hold(3'b101, 3, "R10");
    hold(3'b010, 5, "R1");
    hold(3'b000, 3, "R10");

    // R2: zero delays give no added delay
    nx_db = 3'b111; nx_rise = 12'd0; nx_fall = 12'd0;
    hold(3'b110, 2, "R2");
    hold(3'b011, 2, "R2");

    // longer asymmetric delays, staggered channels
    nx_rise = 12'd5; nx_fall = 12'd1;
    hold(3'b001, 4, "R3");
    hold(3'b011, 7, "R2");
    hold(3'b100, 3, "R5");

    // park on fault
    nx_rise = 12'd3; nx_fall = 12'd2; nx_lvl = 6'b100110; nx_sel = 2'd1;
    hold(3'b111, 2, "R9");
    step(3'b111, 1'b1, 1'b0, "R9");
    step(3'b111, 1'b1, 1'b0, "R8");
    step(3'b000, 1'b1, 1'b0, "R9");
    step(3'b000, 1'b0, 1'b0, "R9");
    step(3'b000, 1'b0, 1'b1, "R7");
    // park on debug only
    nx_sel = 2'd2;
    step(3'b111, 1'b1, 1'b0, "R7");
    step(3'b111, 1'b0, 1'b1, "R7");
    step(3'b111, 1'b0, 1'b0, "R9");
    // park on either, other level pattern
    nx_sel = 2'd3; nx_lvl = 6'b011001;
    step(3'b010, 1'b1, 1'b0, "R8");
    step(3'b010, 1'b0, 1'b1, "R8");
    step(3'b010, 1'b0, 1'b0, "R7");
    // park disabled ignores both
    nx_sel = 2'd0;
    step(3'b010, 1'b1, 1'b1, "R7");
    step(3'b101, 1'b1, 1'b1, "R7");
    hold(3'b101, 4, "R2");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule